// File: doc/BRIEF.md
# Two-Level Nanocoded Control Sequencer

This block is a microprogrammed control unit in which control is split across two stores. A microprogram counter (µPC) addresses a narrow micro store. Each 17-bit microword is either a branch word, which steers the µPC, or a pointer word, which selects one entry of a wider 68-bit nano store. The selected nanoword is expanded by fixed one-hot field decoders into 196 datapath control strobes. Microwords that share a control pattern point at the same nanoword, so each pattern is stored only once.

Both stores can be written through their own write ports, which lets a control program be loaded or corrected after the hardware is built. Writes are taken only while the sequencer is halted. A run starts with a pulse on `start_i`, which loads the µPC from `start_vec_i`. The run ends when a halt word is reached, and `done_o` then stays high until the next start.

Top module: `nano_ctrl_seq`

## Requirements
- R1: After reset the sequencer is halted: `busy_o`=0, `done_o`=0, and `ctrl_o` is all zero. `ctrl_o` stays zero whenever `busy_o`=0.
- R2: A `start_i` pulse while halted loads the µPC with `start_vec_i`; `busy_o` rises and `done_o` clears on the next cycle. `start_i` has no effect while busy.
- R3: A microword with bit 16 = 0 is a pointer word. Its nano pointer is bits [8:0]. In that cycle `ctrl_o` carries the expansion of the nanoword at that pointer, and the µPC then advances by one.
- R4: A microword with bit 16 = 1 is a branch word. Its target is bits [9:0] and its condition select is bits [15:13]. Select 0 always branches, and select k in 1..6 tests `flags_i[k-1]`. When the condition is true the µPC loads the target; otherwise it advances by one. `ctrl_o` is zero in a branch cycle.
- R5: A branch word with select 7 halts the sequencer. `ctrl_o` is zero in that cycle, and on the next cycle `busy_o`=0 and `done_o`=1. `done_o` holds until the next start.
- R6: Nanoword expansion works as follows:
  - Nano bits [4:0] and [9:5] are 5-bit fields. A value v≠0 in field i sets `ctrl_o[31*i+v-1]`.
  - Nano bits [10+3j+2:10+3j], for j in 0..18, are 3-bit fields. A value v≠0 sets `ctrl_o[62+7*j+v-1]`.
  - Nano bit 67 drives `ctrl_o[195]` directly.
  - A field value of 0 asserts no strobe.
- R7: A store write is committed at the clock edge only while halted. A write attempted while busy leaves the store unchanged.
- R8: Several microwords pointing at one nanoword produce identical `ctrl_o` values.
- R9: The µPC advances from 1023 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, honoured while halted |
| start_vec_i | input | 10 | Entry address loaded into the µPC at start |
| flags_i | input | 6 | Condition flags tested by branch words |
| uwe_i | input | 1 | Micro store write enable |
| uwaddr_i | input | 10 | Micro store write address |
| uwdata_i | input | 17 | Micro store write data |
| nwe_i | input | 1 | Nano store write enable |
| nwaddr_i | input | 9 | Nano store write address |
| nwdata_i | input | 68 | Nano store write data |
| ctrl_o | output | 196 | Expanded control strobes |
| busy_o | output | 1 | Sequencer running |
| done_o | output | 1 | Last run ended on a halt word |

## Verification
The bench walks every one of the 196 strobes through its own nanoword. A decoder with an off-by-one error, or a field placed at the wrong offset, would light the wrong bit. Every condition select is tried with its flag true and false, with the other flags set opposite, so a select that indexes the wrong flag, or a branch that leaks control strobes, shows up at once. Writes and a second start are attempted in the middle of a looping run; a sequencer that accepted them would restart or replay patched words. A run across address 1023 catches a µPC that saturates instead of wrapping.

// File: rtl/nseq_pkg.sv
package nseq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/nseq_store.sv
module nseq_store #(
  parameter int AW = 10,
  parameter int DW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];

  assert_write_commit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/nseq_field_dec.sv
module nseq_field_dec #(
  parameter int W = 3
) (
  input  logic [W-1:0]      code_i,
  output logic [2**W-2:0]   strobe_o
);
  always_comb begin
    strobe_o = '0;
    if (code_i != '0) strobe_o[code_i - 1'b1] = 1'b1;
  end
endmodule

// File: rtl/nseq_expand.sv
module nseq_expand #(
  parameter int WIDE_FIELDS   = 2,
  parameter int WIDE_W        = 5,
  parameter int NARROW_FIELDS = 19,
  parameter int NARROW_W      = 3,
  parameter int DIRECT_BITS   = 1,
  localparam int WS     = 2 ** WIDE_W - 1,
  localparam int NS     = 2 ** NARROW_W - 1,
  localparam int NANO_W = WIDE_FIELDS * WIDE_W + NARROW_FIELDS * NARROW_W + DIRECT_BITS,
  localparam int CTRL_W = WIDE_FIELDS * WS + NARROW_FIELDS * NS + DIRECT_BITS
) (
  input  logic [NANO_W-1:0] nano_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  localparam int NB0 = WIDE_FIELDS * WIDE_W;
  localparam int CB0 = WIDE_FIELDS * WS;

  for (genvar gi = 0; gi < WIDE_FIELDS; gi++) begin : g_wide
    nseq_field_dec #(.W(WIDE_W)) u_dec (
      .code_i  (nano_i[gi*WIDE_W +: WIDE_W]),
      .strobe_o(ctrl_o[gi*WS +: WS])
    );
  end

  for (genvar gj = 0; gj < NARROW_FIELDS; gj++) begin : g_narrow
    nseq_field_dec #(.W(NARROW_W)) u_dec (
      .code_i  (nano_i[NB0 + gj*NARROW_W +: NARROW_W]),
      .strobe_o(ctrl_o[CB0 + gj*NS +: NS])
    );
  end

  if (DIRECT_BITS > 0) begin : g_direct
    assign ctrl_o[CTRL_W-1 -: DIRECT_BITS] = nano_i[NANO_W-1 -: DIRECT_BITS];
  end
endmodule

// File: rtl/nseq_seq.sv
module nseq_seq
  import nseq_pkg::*;
#(
  parameter int UADDR_W = 10,
  parameter int NPTR_W  = 9,
  parameter int UWORD_W = 17,
  parameter int COND_W  = 3,
  localparam int NFLAGS = 2 ** COND_W - 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [UADDR_W-1:0] start_vec_i,
  input  logic [NFLAGS-1:0]  flags_i,
  input  logic [UWORD_W-1:0] uword_i,
  output logic [UADDR_W-1:0] upc_o,
  output logic [NPTR_W-1:0]  nptr_o,
  output logic               issue_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam logic [COND_W-1:0] SEL_HALT = '1;

  seq_state_e         state_q;
  logic [UADDR_W-1:0] upc_q;
  logic               done_q;

  logic               is_jump;
  logic [COND_W-1:0]  sel;
  logic [UADDR_W-1:0] target;
  logic [NFLAGS+1:0]  cond_vec;
  logic               cond;
  logic               halt;
  logic               unused_rsv;

  assign is_jump    = uword_i[UWORD_W-1];
  assign sel        = uword_i[UWORD_W-2 -: COND_W];
  assign target     = uword_i[UADDR_W-1:0];
  assign unused_rsv = ^uword_i[UWORD_W-2-COND_W:UADDR_W];
  // select 0 = always, top select = halt (never a branch)
  assign cond_vec   = {1'b0, flags_i, 1'b1};
  assign cond       = cond_vec[sel];
  assign busy_o     = (state_q == ST_RUN);
  assign halt       = busy_o && is_jump && (sel == SEL_HALT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      upc_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            upc_q   <= start_vec_i;
            done_q  <= 1'b0;
          end
        end
        ST_RUN: begin
          if (halt) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else if (is_jump && cond) begin
            upc_q <= target;
          end else begin
            upc_q <= upc_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign upc_o   = upc_q;
  assign nptr_o  = uword_i[NPTR_W-1:0];
  assign issue_o = busy_o && !is_jump;
  assign done_o  = done_q;

  assert_start_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i |=> busy_o && !done_o && upc_q == $past(start_vec_i));

  assert_ptr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !is_jump |=> busy_o && upc_q == $past(upc_q) + 1'b1);

  assert_branch_taken_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && is_jump && sel != SEL_HALT && cond |=> busy_o && upc_q == $past(target));

  assert_halt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt |=> !busy_o && done_o);

  assert_done_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);
endmodule

// File: rtl/nano_ctrl_seq.sv
module nano_ctrl_seq #(
  parameter int UADDR_W       = 10,
  parameter int NPTR_W        = 9,
  parameter int UWORD_W       = 17,
  parameter int COND_W        = 3,
  parameter int WIDE_FIELDS   = 2,
  parameter int WIDE_W        = 5,
  parameter int NARROW_FIELDS = 19,
  parameter int NARROW_W      = 3,
  parameter int DIRECT_BITS   = 1,
  localparam int NFLAGS = 2 ** COND_W - 2,
  localparam int NANO_W = WIDE_FIELDS * WIDE_W + NARROW_FIELDS * NARROW_W + DIRECT_BITS,
  localparam int CTRL_W = WIDE_FIELDS * (2 ** WIDE_W - 1)
                        + NARROW_FIELDS * (2 ** NARROW_W - 1) + DIRECT_BITS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [UADDR_W-1:0] start_vec_i,
  input  logic [NFLAGS-1:0]  flags_i,
  input  logic               uwe_i,
  input  logic [UADDR_W-1:0] uwaddr_i,
  input  logic [UWORD_W-1:0] uwdata_i,
  input  logic               nwe_i,
  input  logic [NPTR_W-1:0]  nwaddr_i,
  input  logic [NANO_W-1:0]  nwdata_i,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int MAX_STROBES = WIDE_FIELDS + NARROW_FIELDS + DIRECT_BITS;

  logic [UADDR_W-1:0] upc;
  logic [UWORD_W-1:0] uword;
  logic [NPTR_W-1:0]  nptr;
  logic [NANO_W-1:0]  nword;
  logic [CTRL_W-1:0]  strobes;
  logic               issue;
  logic               u_we;
  logic               n_we;

  // stores are patchable only while halted
  assign u_we = uwe_i && !busy_o;
  assign n_we = nwe_i && !busy_o;

  nseq_store #(.AW(UADDR_W), .DW(UWORD_W)) u_ustore (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (u_we),
    .waddr_i(uwaddr_i),
    .wdata_i(uwdata_i),
    .raddr_i(upc),
    .rdata_o(uword)
  );

  nseq_store #(.AW(NPTR_W), .DW(NANO_W)) u_nstore (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (n_we),
    .waddr_i(nwaddr_i),
    .wdata_i(nwdata_i),
    .raddr_i(nptr),
    .rdata_o(nword)
  );

  nseq_seq #(
    .UADDR_W(UADDR_W),
    .NPTR_W (NPTR_W),
    .UWORD_W(UWORD_W),
    .COND_W (COND_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .start_vec_i(start_vec_i),
    .flags_i    (flags_i),
    .uword_i    (uword),
    .upc_o      (upc),
    .nptr_o     (nptr),
    .issue_o    (issue),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  nseq_expand #(
    .WIDE_FIELDS  (WIDE_FIELDS),
    .WIDE_W       (WIDE_W),
    .NARROW_FIELDS(NARROW_FIELDS),
    .NARROW_W     (NARROW_W),
    .DIRECT_BITS  (DIRECT_BITS)
  ) u_expand (
    .nano_i(nword),
    .ctrl_o(strobes)
  );

  assign ctrl_o = issue ? strobes : '0;

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ctrl_o == '0);

  assert_branch_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && uword[UWORD_W-1] |-> ctrl_o == '0);

  assert_field_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $countones(ctrl_o) <= MAX_STROBES);
endmodule

// File: tb/nano_ctrl_seq_test.sv
`timescale 1ns/1ps
module nano_ctrl_seq_test;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [9:0]   start_vec_i = '0;
  logic [5:0]   flags_i = '0;
  logic         uwe_i = 1'b0;
  logic [9:0]   uwaddr_i = '0;
  logic [16:0]  uwdata_i = '0;
  logic         nwe_i = 1'b0;
  logic [8:0]   nwaddr_i = '0;
  logic [67:0]  nwdata_i = '0;
  logic [195:0] ctrl_o;
  logic         busy_o;
  logic         done_o;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  nano_ctrl_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .start_vec_i(start_vec_i),
    .flags_i(flags_i), .uwe_i(uwe_i), .uwaddr_i(uwaddr_i), .uwdata_i(uwdata_i),
    .nwe_i(nwe_i), .nwaddr_i(nwaddr_i), .nwdata_i(nwdata_i),
    .ctrl_o(ctrl_o), .busy_o(busy_o), .done_o(done_o)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish, got %0d cycles exp fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  function automatic logic [16:0] uw_ptr(input int p);
    return {1'b1 ^ 1'b1, 7'b0, p[8:0]};
  endfunction

  function automatic logic [16:0] uw_br(input int sel, input int tgt);
    return {1'b1, sel[2:0], 3'b0, tgt[9:0]};
  endfunction

  function automatic logic [67:0] nano_for_strobe(input int s);
    logic [67:0] w = '0;
    if (s < 62)       w[5*(s/31) +: 5] = 5'((s % 31) + 1);
    else if (s < 195) w[10 + 3*((s-62)/7) +: 3] = 3'(((s-62) % 7) + 1);
    else              w[67] = 1'b1;
    return w;
  endfunction

  function automatic logic [195:0] expect_ctrl(input logic [67:0] w);
    logic [195:0] e = '0;
    for (int i = 0; i < 2; i++)
      if (w[5*i +: 5] != 0) e[31*i + int'(w[5*i +: 5]) - 1] = 1'b1;
    for (int j = 0; j < 19; j++)
      if (w[10+3*j +: 3] != 0) e[62 + 7*j + int'(w[10+3*j +: 3]) - 1] = 1'b1;
    e[195] = w[67];
    return e;
  endfunction

  function automatic logic [195:0] one_hot(input int s);
    logic [195:0] e = '0;
    e[s] = 1'b1;
    return e;
  endfunction

  task automatic chk_ctrl(input string req, input logic [195:0] exp);
    n_checks++;
    if (ctrl_o !== exp) begin
      n_fail++;
      $display("FAIL %s ctrl_o got %h exp %h", req, ctrl_o, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %b exp %b", req, got, exp);
    end
  endtask

  task automatic wr_u(input int a, input logic [16:0] d);
    uwe_i = 1'b1; uwaddr_i = a[9:0]; uwdata_i = d;
    @(negedge clk);
    uwe_i = 1'b0;
  endtask

  task automatic wr_n(input int a, input logic [67:0] d);
    nwe_i = 1'b1; nwaddr_i = a[8:0]; nwdata_i = d;
    @(negedge clk);
    nwe_i = 1'b0;
  endtask

  task automatic run_from(input int sv);
    start_vec_i = sv[9:0]; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic finish_halt(input string req);
    chk_ctrl({req, " halt cycle quiet"}, '0);
    @(negedge clk);
    chk_bit({req, " busy after halt"}, busy_o, 1'b0);
    chk_bit({req, " done after halt"}, done_o, 1'b1);
  endtask

  initial begin
    logic [67:0] comp_a;
    logic [67:0] comp_b;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_bit("R1 busy", busy_o, 1'b0);
    chk_bit("R1 done", done_o, 1'b0);
    chk_ctrl("R1 ctrl", '0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R6 R3 sweep of every strobe
    for (int s = 0; s < 196; s++) begin
      wr_n(s, nano_for_strobe(s));
      wr_u(s, uw_ptr(s));
    end
    wr_n(400 - 100, '0);
    wr_u(196, uw_ptr(300));
    wr_u(197, uw_br(7, 0));
    chk_ctrl("R1 idle quiet after writes", '0);
    run_from(0);
    chk_bit("R2 done cleared at start", done_o, 1'b0);
    for (int s = 0; s < 196; s++) begin
      chk_ctrl($sformatf("R6 R3 strobe %0d", s), one_hot(s));
      @(negedge clk);
    end
    chk_ctrl("R6 zero fields give no strobe", '0);
    chk_bit("R3 busy on zero word", busy_o, 1'b1);
    @(negedge clk);
    finish_halt("R5");
    @(negedge clk);
    chk_bit("R5 done holds while idle", done_o, 1'b1);

    // R8 shared nanowords
    comp_a = '0; comp_b = '0;
    comp_a[4:0] = 5'd5; comp_a[9:5] = 5'd31; comp_a[67] = 1'b1;
    comp_b[4:0] = 5'd17; comp_b[9:5] = 5'd1;
    for (int j = 0; j < 19; j++) begin
      comp_a[10+3*j +: 3] = 3'((j % 7) + 1);
      comp_b[10+3*j +: 3] = 3'(7 - (j % 8));
    end
    wr_n(301, comp_a);
    wr_n(302, comp_b);
    wr_u(200, uw_ptr(301));
    wr_u(201, uw_ptr(302));
    wr_u(202, uw_ptr(301));
    wr_u(203, uw_ptr(302));
    wr_u(204, uw_br(7, 0));
    run_from(200);
    for (int k = 0; k < 4; k++) begin
      chk_ctrl($sformatf("R8 shared word step %0d", k),
               expect_ctrl((k % 2 == 0) ? comp_a : comp_b));
      @(negedge clk);
    end
    finish_halt("R8");

    // R4 every condition select, flag true and false
    wr_u(401, uw_ptr(1));
    wr_u(402, uw_br(7, 0));
    wr_u(410, uw_ptr(2));
    wr_u(411, uw_br(7, 0));
    for (int sel = 0; sel < 7; sel++) begin
      for (int t = 0; t < 2; t++) begin
        bit taken;
        if (sel == 0) begin
          flags_i = t ? 6'h00 : 6'h3f;
          taken = 1'b1;
        end else begin
          flags_i = t ? 6'(1 << (sel - 1)) : ~6'(1 << (sel - 1));
          taken = bit'(t);
        end
        wr_u(400, uw_br(sel, 410));
        run_from(400);
        chk_ctrl($sformatf("R4 branch cycle quiet sel %0d", sel), '0);
        @(negedge clk);
        chk_ctrl($sformatf("R4 sel %0d flag %0d outcome", sel, t),
                 one_hot(taken ? 2 : 1));
        @(negedge clk);
        finish_halt("R4");
      end
    end

    // R2 R7 start and writes ignored while busy
    wr_u(500, uw_ptr(5));
    wr_u(501, uw_br(1, 500));
    wr_u(502, uw_br(7, 0));
    flags_i = 6'h01;
    run_from(500);
    chk_ctrl("R2 loop first word", one_hot(5));
    start_vec_i = 10'd0; start_i = 1'b1;
    uwe_i = 1'b1; uwaddr_i = 10'd502; uwdata_i = uw_ptr(7);
    nwe_i = 1'b1; nwaddr_i = 9'd5; nwdata_i = nano_for_strobe(8);
    @(negedge clk);
    start_i = 1'b0; uwe_i = 1'b0; nwe_i = 1'b0;
    chk_ctrl("R2 start while busy ignored", '0);
    @(negedge clk);
    chk_ctrl("R2 loop back", one_hot(5));
    flags_i = 6'h00;
    @(negedge clk);
    chk_ctrl("R4 fall through cycle", '0);
    @(negedge clk);
    finish_halt("R7 micro write while busy ignored");
    run_from(500);
    chk_ctrl("R7 nano write while busy ignored", one_hot(5));
    @(negedge clk);
    @(negedge clk);
    finish_halt("R7 rerun");

    // R9 wrap past the top address
    wr_u(1023, uw_ptr(9));
    wr_u(0, uw_ptr(10));
    wr_u(1, uw_br(7, 0));
    run_from(1023);
    chk_ctrl("R9 top address", one_hot(9));
    @(negedge clk);
    chk_ctrl("R9 wrapped to zero", one_hot(10));
    @(negedge clk);
    finish_halt("R9");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule